// File: doc/BRIEF.md
# General-Purpose Event Register Block with SCI Control

This block holds the general-purpose event (GPE) registers of a power-management function. It has a bank of byte-wide status registers and a bank of byte-wide enable registers. It drives one level-sensitive system control interrupt (SCI) line. Hardware event inputs set status bits. Software clears a status bit by writing a one to it, and it programs each enable byte by writing the whole byte.

One event bit is special: the hotplug event, which is event bit 3. It sits at bit 3 of status byte 0, and bit 3 of enable byte 0 is its enable. Only this bit drives the SCI. The SCI goes high when an enabled hotplug event arrives. It goes low when software clears the pending hotplug status or disables the hotplug enable. Setting the enable later, while a hotplug status is already pending, does not raise the SCI.

The same local address space also holds a 32-byte processor-presence bitmap, which software can only read. Reads are combinational from the current register state. Writes and events take effect at the rising clock edge.

Top module: `gpe_sci_block`

## Requirements
- R1: Address map of the 7-bit local offset: status bytes at offsets 0x00–0x03, enable bytes at 0x04–0x07, processor-presence bitmap at 0x40–0x5F. A read of any other offset returns 0x00, and a write to any other offset changes no state.
- R2: A one on event input bit n during a clock edge sets status byte n/8, bit n%8. The bit stays set until software clears it.
- R3: A write to a status byte clears every bit written as 1 and leaves the bits written as 0 unchanged.
- R4: A write to an enable byte replaces all 8 bits of that byte with the written data.
- R5: A hotplug event (evt_i bit 3) at an edge where enable byte 0 bit 3 is 1 sets sci_o high from that edge on. Without the enable, the event raises no SCI. Setting the enable afterwards, while the status is still pending, leaves sci_o low.
- R6: While sci_o is high, a write to status byte 0 that clears a set bit 3 drives sci_o low at that edge. A status write that leaves bit 3 set leaves sci_o high.
- R7: While sci_o is high, a write to enable byte 0 with data bit 3 equal to 0 drives sci_o low. A write with data bit 3 equal to 1 leaves sci_o high.
- R8: When an event and a write arrive at the same edge, the status write is applied first and the event then sets its bit, so the event wins. The SCI decision for a hotplug event uses the enable byte value after a same-edge enable write.
- R9: After reset, processor-presence byte 0 reads 0x01 and bytes 1–31 read 0x00. Writes to the bitmap have no effect.
- R10: Reset clears all status bytes and all enable bytes to 0x00 and drives sci_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 7 | Local byte offset for reads and writes |
| wr_i | input | 1 | Write strobe, one byte per cycle |
| wdata_i | input | 8 | Write data |
| evt_i | input | 32 | Event inputs. Each set bit sets its status bit at the edge. |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| sci_o | output | 1 | Level SCI output |

## Verification
The assertions assume that every set bit on evt_i is a single-cycle pulse and that addr_i and wr_i are stable around the sampling edge. They also assume that a drop of sci_o can only follow a write to offset 0x00 or 0x04.

The stimulus raises events and writes only at the falling edge and releases them one cycle later. It therefore never holds an event across two edges. Same-edge collisions between an event and a write are created on purpose, so the ordering rule is exercised under the same assumptions.

// File: rtl/gpe_pkg.sv
package gpe_pkg;
  localparam int GPE_ADDR_W    = 7;
  localparam int GPE_BYTES     = 4;
  localparam int GPE_CPU_BYTES = 32;
  localparam int GPE_CPU_BASE  = 64;
  localparam int GPE_HP_BIT    = 3;
endpackage

// File: rtl/gpe_status_bank.sv
module gpe_status_bank #(
  parameter int NBYTES = gpe_pkg::GPE_BYTES
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NBYTES-1:0]     we_i,
  input  logic [7:0]            wdata_i,
  input  logic [NBYTES*8-1:0]   evt_i,
  output logic [NBYTES*8-1:0]   sts_o
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [7:0] clr;
    assign clr = we_i[b] ? wdata_i : 8'h00;
    // clear first, event sets afterwards so an event is never lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sts_o[b*8 +: 8] <= 8'h00;
      else         sts_o[b*8 +: 8] <= (sts_o[b*8 +: 8] & ~clr) | evt_i[b*8 +: 8];
    end
  end
endmodule

// File: rtl/gpe_enable_bank.sv
module gpe_enable_bank #(
  parameter int NBYTES = gpe_pkg::GPE_BYTES
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NBYTES-1:0]     we_i,
  input  logic [7:0]            wdata_i,
  output logic [NBYTES*8-1:0]   en_o
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      en_o[b*8 +: 8] <= 8'h00;
      else if (we_i[b]) en_o[b*8 +: 8] <= wdata_i;
    end
  end
endmodule

// File: rtl/gpe_sci_ctrl.sv
module gpe_sci_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hp_evt_i,
  input  logic hp_sts_i,
  input  logic hp_en_i,
  input  logic sts0_we_i,
  input  logic en0_we_i,
  input  logic hp_wbit_i,
  output logic sci_o
);
  logic en_next, drop_en, drop_sts;

  assign en_next  = en0_we_i ? hp_wbit_i : hp_en_i;
  assign drop_en  = en0_we_i && !hp_wbit_i;
  assign drop_sts = sts0_we_i && hp_wbit_i && hp_sts_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  sci_o <= 1'b0;
    else if (hp_evt_i && en_next) sci_o <= 1'b1;
    else if (sci_o && drop_en)    sci_o <= 1'b0;
    else if (sci_o && drop_sts)   sci_o <= 1'b0;
  end
endmodule

// File: rtl/gpe_cpu_map.sv
module gpe_cpu_map #(
  parameter int NBYTES = gpe_pkg::GPE_CPU_BYTES,
  localparam int IW    = $clog2(NBYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] idx_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] map_q [NBYTES];

  // read-only to software; only reset defines the contents
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) map_q[b] <= (b == 0) ? 8'h01 : 8'h00;
      else         map_q[b] <= map_q[b];
    end
  end

  assign rdata_o = map_q[idx_i];
endmodule

// File: rtl/gpe_sci_block.sv
module gpe_sci_block #(
  parameter int ADDR_W    = gpe_pkg::GPE_ADDR_W,
  parameter int GPE_BYTES = gpe_pkg::GPE_BYTES,
  parameter int CPU_BYTES = gpe_pkg::GPE_CPU_BYTES,
  parameter int CPU_BASE  = gpe_pkg::GPE_CPU_BASE,
  parameter int HP_BIT    = gpe_pkg::GPE_HP_BIT,
  localparam int EVT_W    = GPE_BYTES * 8,
  localparam int GIW      = $clog2(GPE_BYTES),
  localparam int CIW      = $clog2(CPU_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  input  logic [EVT_W-1:0]  evt_i,
  output logic [7:0]        rdata_o,
  output logic              sci_o
);
  // bases are aligned to their region sizes, so low address bits index directly
  logic             sel_sts, sel_en, sel_cpu;
  logic [GIW-1:0]   gidx;
  logic [GPE_BYTES-1:0] sts_we, en_we;
  logic [EVT_W-1:0] sts_q, en_q;
  logic [7:0]       cpu_rd;
  logic             hp_en_q;

  assign sel_sts = addr_i < ADDR_W'(GPE_BYTES);
  assign sel_en  = (addr_i >= ADDR_W'(GPE_BYTES)) && (addr_i < ADDR_W'(2 * GPE_BYTES));
  assign sel_cpu = (addr_i >= ADDR_W'(CPU_BASE)) && (addr_i < ADDR_W'(CPU_BASE + CPU_BYTES));
  assign gidx    = addr_i[GIW-1:0];

  for (genvar b = 0; b < GPE_BYTES; b++) begin : g_dec
    assign sts_we[b] = wr_i && sel_sts && (gidx == GIW'(b));
    assign en_we[b]  = wr_i && sel_en  && (gidx == GIW'(b));
  end

  gpe_status_bank #(.NBYTES(GPE_BYTES)) u_sts (
    .clk_i, .rst_ni, .we_i(sts_we), .wdata_i, .evt_i, .sts_o(sts_q)
  );

  gpe_enable_bank #(.NBYTES(GPE_BYTES)) u_en (
    .clk_i, .rst_ni, .we_i(en_we), .wdata_i, .en_o(en_q)
  );

  assign hp_en_q = en_q[HP_BIT];

  gpe_sci_ctrl u_sci (
    .clk_i, .rst_ni,
    .hp_evt_i (evt_i[HP_BIT]),
    .hp_sts_i (sts_q[HP_BIT]),
    .hp_en_i  (hp_en_q),
    .sts0_we_i(sts_we[HP_BIT / 8]),
    .en0_we_i (en_we[HP_BIT / 8]),
    .hp_wbit_i(wdata_i[HP_BIT % 8]),
    .sci_o
  );

  gpe_cpu_map #(.NBYTES(CPU_BYTES)) u_cpu (
    .clk_i, .rst_ni, .idx_i(addr_i[CIW-1:0]), .rdata_o(cpu_rd)
  );

  always_comb begin
    rdata_o = 8'h00;
    if (sel_sts)      rdata_o = sts_q[gidx*8 +: 8];
    else if (sel_en)  rdata_o = en_q[gidx*8 +: 8];
    else if (sel_cpu) rdata_o = cpu_rd;
  end
endmodule

// File: rtl/gpe_sci_chk.sv
module gpe_sci_chk #(
  parameter int ADDR_W    = gpe_pkg::GPE_ADDR_W,
  parameter int GPE_BYTES = gpe_pkg::GPE_BYTES,
  parameter int CPU_BASE  = gpe_pkg::GPE_CPU_BASE,
  parameter int HP_BIT    = gpe_pkg::GPE_HP_BIT
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [ADDR_W-1:0]      addr_i,
  input logic                   wr_i,
  input logic [7:0]             wdata_i,
  input logic [GPE_BYTES*8-1:0] evt_i,
  input logic [7:0]             rdata_o,
  input logic                   sci_o,
  input logic                   hp_en_i
);
  localparam logic [ADDR_W-1:0] EN0 = ADDR_W'(GPE_BYTES);

  AST_SCI_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sci_o) |-> $past(evt_i[HP_BIT])); // R5

  AST_EVT_ASSERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[HP_BIT] && hp_en_i && !wr_i |=> sci_o); // R5

  AST_SCI_FALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sci_o) |-> $past(wr_i) && ($past(addr_i) == '0 || $past(addr_i) == EN0)); // R6

  AST_EN_CLEAR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sci_o && wr_i && addr_i == EN0 && !wdata_i[HP_BIT] && !evt_i[HP_BIT] |=> !sci_o); // R7

  AST_CPU_BYTE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADDR_W'(CPU_BASE) |-> rdata_o == 8'h01); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i >= ADDR_W'(2 * GPE_BYTES) && addr_i < ADDR_W'(CPU_BASE) |-> rdata_o == 8'h00); // R1
endmodule

bind gpe_sci_block gpe_sci_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
  .evt_i(evt_i), .rdata_o(rdata_o), .sci_o(sci_o), .hp_en_i(hp_en_q)
);

// File: tb/gpe_sci_block_bench.sv
`timescale 1ns/1ps
module gpe_sci_block_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  addr = '0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [31:0] evt = '0;
  logic [7:0]  rdata;
  logic        sci;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    bit         is_sci;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  logic [7:0] m_sts [4];
  logic [7:0] m_en  [4];
  logic       m_sci;

  always #2 clk = ~clk;

  gpe_sci_block u_gpe_sci_block (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .evt_i(evt), .rdata_o(rdata), .sci_o(sci)
  );

  // monitor: pops expected items and compares with live outputs
  initial begin
    forever begin
      wait (sb_q.size() > 0);
      #0.5;
      begin
        item_t it;
        logic [7:0] act;
        it  = sb_q.pop_front();
        act = it.is_sci ? {7'd0, sci} : rdata;
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push_rd(input logic [6:0] a, input logic [7:0] e, input string tag);
    item_t it;
    addr = a;
    it.is_sci = 0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
    #0.5;
  endtask

  task automatic push_sci(input logic e, input string tag);
    item_t it;
    it.is_sci = 1; it.exp = {7'd0, e}; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
    #0.5;
  endtask

  // one bus cycle; the model follows the requirements
  task automatic cyc(input logic [6:0] a, input logic w, input logic [7:0] d, input logic [31:0] ev);
    logic old_hp;
    @(negedge clk);
    addr = a; wr = w; wdata = d; evt = ev;
    @(posedge clk);
    old_hp = m_sts[0][3];
    if (w && a < 7'd4) m_sts[a[1:0]] &= ~d;                   // R3
    if (w && a >= 7'd4 && a < 7'd8) m_en[a[1:0]] = d;          // R4
    for (int b = 0; b < 4; b++) m_sts[b] |= ev[b*8 +: 8];      // R2, R8
    if (ev[3] && m_en[0][3]) m_sci = 1'b1;                     // R5, R8
    else if (m_sci && w && a == 7'd4 && !d[3]) m_sci = 1'b0;   // R7
    else if (m_sci && w && a == 7'd0 && d[3] && old_hp) m_sci = 1'b0; // R6
    @(negedge clk);
    wr = 1'b0; evt = '0;
  endtask

  task automatic chk_all(input string tag);
    for (int b = 0; b < 4; b++) push_rd(7'(b), m_sts[b], tag);
    for (int b = 0; b < 4; b++) push_rd(7'(4 + b), m_en[b], tag);
    push_sci(m_sci, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 4; b++) begin m_sts[b] = 0; m_en[b] = 0; end
    m_sci = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state, R9 bitmap, R1 unmapped
    chk_all("R10 reset");
    push_rd(7'h40, 8'h01, "R9 cpu byte0");
    push_rd(7'h45, 8'h00, "R9 cpu byte5");
    push_rd(7'h10, 8'h00, "R1 unmapped read");

    // R5 event without enable, then late enable
    cyc(7'h00, 0, 8'h00, 32'h8);
    push_rd(7'h00, 8'h08, "R2 hotplug status set");
    push_sci(1'b0, "R5 no sci when disabled");
    cyc(7'h04, 1, 8'h08, 32'h0);
    push_sci(1'b0, "R5 late enable no sci");
    cyc(7'h00, 1, 8'h08, 32'h0);
    push_rd(7'h00, 8'h00, "R3 clear hotplug");

    // R5 assert, R6 partial clear keeps, full clear drops
    cyc(7'h00, 0, 8'h00, 32'h9);
    push_sci(1'b1, "R5 sci asserted");
    cyc(7'h00, 1, 8'h01, 32'h0);
    push_rd(7'h00, 8'h08, "R3 partial clear");
    push_sci(1'b1, "R6 sci kept");
    cyc(7'h00, 1, 8'h08, 32'h0);
    push_sci(1'b0, "R6 sci dropped");

    // R7 enable writes
    cyc(7'h00, 0, 8'h00, 32'h8);
    push_sci(1'b1, "R5 sci asserted again");
    cyc(7'h04, 1, 8'h0C, 32'h0);
    push_sci(1'b1, "R7 sci kept");
    cyc(7'h04, 1, 8'h04, 32'h0);
    push_sci(1'b0, "R7 sci dropped");
    push_rd(7'h04, 8'h04, "R4 enable readback");

    // R2/R3 on other bytes
    cyc(7'h00, 0, 8'h00, 32'h0000_0300);
    cyc(7'h01, 1, 8'h01, 32'h0);
    push_rd(7'h01, 8'h02, "R3 byte1 partial clear");
    cyc(7'h00, 0, 8'h00, 32'h8000_0000);
    push_rd(7'h03, 8'h80, "R2 byte3 bit7");
    cyc(7'h06, 1, 8'hA5, 32'h0);
    push_rd(7'h06, 8'hA5, "R4 enable byte2");

    // R9 and R1 ignored writes
    cyc(7'h40, 1, 8'h00, 32'h0);
    push_rd(7'h40, 8'h01, "R9 write ignored byte0");
    cyc(7'h41, 1, 8'hFF, 32'h0);
    push_rd(7'h41, 8'h00, "R9 write ignored byte1");
    cyc(7'h10, 1, 8'hFF, 32'h0);
    push_rd(7'h10, 8'h00, "R1 unmapped write");
    chk_all("R1 state unchanged");

    // R8 same-edge collisions
    cyc(7'h00, 1, 8'h08, 32'h0);
    cyc(7'h04, 1, 8'h08, 32'h0);
    cyc(7'h00, 1, 8'h08, 32'h8);
    push_rd(7'h00, 8'h08, "R8 event beats clear");
    push_sci(1'b1, "R8 sci after collision");
    cyc(7'h00, 1, 8'h08, 32'h0);
    push_sci(1'b0, "R6 drop after collision");
    cyc(7'h04, 1, 8'h00, 32'h8);
    push_sci(1'b0, "R8 enable write wins");
    cyc(7'h04, 1, 8'h08, 32'h8);
    push_sci(1'b1, "R8 same-edge enable used");
    chk_all("R8 final state");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule